// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-driven engine that runs exactly one serial-flash transaction each time software launches it. Software first loads a command word carrying an opcode and a 24-bit flash address, and may also load a 32-bit data word. It then writes the control word. That word gives a transmit byte count and a receive byte count, and it sets the launch bit. The engine lowers chip select, clocks out the transmit bytes in SPI mode 0, clocks in the receive bytes, and packs those bytes into the data word. Software polls a busy flag to learn when the transaction has finished.

The transmit count covers the opcode, the three address bytes and any payload bytes. Payload bytes come from the data word, least significant byte first. This lets one engine cover several kinds of command:
- single-byte commands such as write enable (1/0) and status read (1/1);
- four-byte addressed commands such as sector erase (4/0), signature read (4/1) and data read (4/4);
- page program with one to four payload bytes (transmit count 5 to 8).

Software splits writes at page boundaries before it launches them.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, MOSI is low, and all three registers read as zero.
- R2: The register offsets are 0 for the command word (opcode in [7:0], address in [31:8]), 1 for control and 2 for data. The command and data words read back as written. Control reads back the transmit count in [3:0], the receive count in [7:4] and busy in bit 16. Bit 8 always reads 0.
- R3: A control write with bit 8 set and a nonzero transmit count, made while idle, sets busy from the next cycle. Busy stays high for exactly (8*(tx+rx)+1)*CLK_DIV system cycles.
- R4: Chip select is low in exactly the cycles in which busy is high, and the serial clock is low whenever chip select is high.
- R5: Mode 0 framing applies. MOSI holds steady while the serial clock is high. Each byte is sent most significant bit first, and MISO is sampled on the rising clock edge. One transaction produces 8*(tx+rx) rising edges.
- R6: The transmit byte order is opcode, address [23:16], address [15:8], address [7:0], then data bytes [7:0], [15:8], [23:16], [31:24], truncated to the transmit count. MOSI is 0 during the receive bytes.
- R7: When the receive count is nonzero, the data word takes receive byte j in bits [8j+7:8j] at the moment busy clears, and unused byte lanes read zero. When the receive count is zero, the data word is left unchanged.
- R8: Transmit counts above 8 are clamped to 8, and receive counts above 4 are clamped to 4. Both the transaction and the control readback use the clamped values.
- R9: A control write made while busy is ignored. The running transaction, its length and its result are unchanged, and so are the stored counts.
- R10: A launch with a transmit count of 0 does not lower chip select, never sets busy, and leaves the data word unchanged.
- R11: The serial clock period is CLK_DIV system cycles, high for CLK_DIV/2 cycles and low for CLK_DIV/2 cycles. Consecutive rising edges are exactly CLK_DIV cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register write offset |
| bus_wdata | input | 32 | Register write data |
| bus_raddr | input | 2 | Register read offset |
| bus_rdata | output | 32 | Register read data (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The timing below counts from the clock edge that captures the control write. Busy rises at that edge. Busy falls (8*(tx+rx)+1)*CLK_DIV edges later, and the data word is updated at that same edge. The first rising serial clock edge comes CLK_DIV/2 edges after the launch, and each later rising edge follows CLK_DIV edges after the one before.

The bench drives every input and samples every output on the falling system clock. It counts the falling edges at which busy reads high, and that count must equal the formula exactly. It detects serial-clock edges by comparing successive falling-edge samples. It reads the data word only after busy has been seen low, so every sample falls half a cycle after the edge that produced the value.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int TX_MAX = 8;
  localparam int RX_MAX = 4;

  localparam logic [1:0] OFS_CMD  = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_DATA = 2'd2;

  localparam int CTRL_LAUNCH_BIT = 8;
  localparam int CTRL_BUSY_BIT   = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } seq_state_e;

  function automatic logic [3:0] clamp_tx(input logic [3:0] v);
    return (v > 4'(TX_MAX)) ? 4'(TX_MAX) : v;
  endfunction

  function automatic logic [2:0] clamp_rx(input logic [3:0] v);
    return (v > 4'(RX_MAX)) ? 3'(RX_MAX) : v[2:0];
  endfunction

  // Index of the final bit of a transaction, counted from 0.
  function automatic logic [6:0] final_bit(input logic [3:0] tx, input logic [2:0] rx);
    logic [6:0] nbytes;
    nbytes = {3'd0, tx} + {4'd0, rx};
    return 7'((nbytes << 3) - 7'd1);
  endfunction

  // Byte k of the outgoing stream.
  function automatic logic [7:0] out_byte(input logic [31:0] cmd, input logic [31:0] data,
                                          input logic [3:0] k);
    case (k)
      4'd0:    return cmd[7:0];
      4'd1:    return cmd[31:24];
      4'd2:    return cmd[23:16];
      4'd3:    return cmd[15:8];
      4'd4:    return data[7:0];
      4'd5:    return data[15:8];
      4'd6:    return data[23:16];
      4'd7:    return data[31:24];
      default: return 8'h00;
    endcase
  endfunction

  // Position in the receive word of the bit now being sampled.
  function automatic logic [4:0] in_bit_pos(input logic [3:0] cur_byte, input logic [3:0] tx,
                                            input logic [2:0] bit_in);
    logic [1:0] lane;
    lane = 2'(cur_byte - tx);
    return {lane, ~bit_in};
  endfunction

endpackage

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R11: the half-period counter never leaves its range
  a_r11_cnt_range: assert property (@(posedge clk) disable iff (!rst_n) cnt < CW'(HALF));
  // R11: no clock edge is requested while the engine is idle
  a_r11_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !tick);

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [1:0]  bus_raddr,
  output logic [31:0] bus_rdata,
  input  logic        busy,
  input  logic        seq_done,
  input  logic [31:0] rx_word,
  output logic [31:0] cmd_q,
  output logic [31:0] data_q,
  output logic        start_req,
  output logic [3:0]  req_tx,
  output logic [2:0]  req_rx
);
  logic [3:0] tx_q;
  logic [2:0] rx_q;
  logic       ctrl_wr;

  assign ctrl_wr   = bus_wr && (bus_addr == OFS_CTRL) && !busy;
  assign req_tx    = clamp_tx(bus_wdata[3:0]);
  assign req_rx    = clamp_rx(bus_wdata[7:4]);
  assign start_req = ctrl_wr && bus_wdata[CTRL_LAUNCH_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      if (bus_wr && bus_addr == OFS_CMD) cmd_q <= bus_wdata;
      if (ctrl_wr) begin
        tx_q <= req_tx;
        rx_q <= req_rx;
      end
      if (seq_done && rx_q != 3'd0)             data_q <= rx_word;
      else if (bus_wr && bus_addr == OFS_DATA) data_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_raddr)
      OFS_CMD:  bus_rdata = cmd_q;
      OFS_CTRL: begin
        bus_rdata[3:0]           = tx_q;
        bus_rdata[7:4]           = {1'b0, rx_q};
        bus_rdata[CTRL_BUSY_BIT] = busy;
      end
      OFS_DATA: bus_rdata = data_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R3: a valid launch makes the sequencer busy on the next cycle
  a_r3_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && req_tx != 4'd0) |=> busy);
  // R10: a zero-length launch never makes the sequencer busy
  a_r10_zero_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && req_tx == 4'd0) |=> !busy);
  // R9: control writes during a transaction leave the stored counts alone
  a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == OFS_CTRL) |=> ($stable(tx_q) && $stable(rx_q)));
  // R7: at completion with a receive phase, the data word takes the received bytes
  a_r7_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && rx_q != 3'd0) |=> data_q == $past(rx_word));
  // R8: the stored counts never exceed their limits
  a_r8_counts_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_q <= 4'(TX_MAX)) && (rx_q <= 3'(RX_MAX)));

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_req,
  input  logic [3:0]  req_tx,
  input  logic [2:0]  req_rx,
  input  logic [31:0] cmd_q,
  input  logic [31:0] data_q,
  input  logic        tick,
  input  logic        miso,
  output logic        cs_n,
  output logic        sck,
  output logic        mosi,
  output logic        busy,
  output logic        seq_done,
  output logic [31:0] rx_word
);
  seq_state_e  state;
  logic [6:0]  bcnt;
  logic [6:0]  last_bit;
  logic [31:0] s_cmd;
  logic [31:0] s_data;
  logic [3:0]  s_tx;
  logic [31:0] rx_acc;
  logic        tail_half;

  logic        launch;
  logic [3:0]  cur_byte;
  logic [2:0]  bit_in;
  logic        in_tx;
  logic [7:0]  cur_out;
  logic [4:0]  rx_pos;

  assign launch   = start_req && (req_tx != 4'd0);
  assign cur_byte = bcnt[6:3];
  assign bit_in   = bcnt[2:0];
  assign in_tx    = cur_byte < s_tx;
  assign cur_out  = out_byte(s_cmd, s_data, cur_byte);
  assign rx_pos   = in_bit_pos(cur_byte, s_tx, bit_in);
  assign mosi     = (state == ST_SHIFT) && in_tx && cur_out[3'd7 - bit_in];
  assign seq_done = (state == ST_TAIL) && tick && tail_half;
  assign rx_word  = rx_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cs_n      <= 1'b1;
      sck       <= 1'b0;
      busy      <= 1'b0;
      bcnt      <= '0;
      last_bit  <= '0;
      s_cmd     <= '0;
      s_data    <= '0;
      s_tx      <= '0;
      rx_acc    <= '0;
      tail_half <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (launch) begin
            state    <= ST_SHIFT;
            cs_n     <= 1'b0;
            sck      <= 1'b0;
            busy     <= 1'b1;
            bcnt     <= '0;
            last_bit <= final_bit(req_tx, req_rx);
            s_cmd    <= cmd_q;
            s_data   <= data_q;
            s_tx     <= req_tx;
            rx_acc   <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sck) begin
              sck <= 1'b1;
              if (!in_tx) rx_acc[rx_pos] <= miso;
            end else begin
              sck <= 1'b0;
              if (bcnt == last_bit) begin
                state     <= ST_TAIL;
                tail_half <= 1'b0;
              end else begin
                bcnt <= bcnt + 7'd1;
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            if (tail_half) begin
              state <= ST_IDLE;
              cs_n  <= 1'b1;
              busy  <= 1'b0;
            end else begin
              tail_half <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: the serial clock stays low while chip select is released
  a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  // R5: MOSI holds steady across the high phase of the serial clock
  a_r5_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck && $past(sck)) |-> $stable(mosi));
  // R10: a zero-length launch leaves chip select high
  a_r10_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_req && req_tx == 4'd0) |=> cs_n);
  // R8: the bit counter never passes twelve bytes
  a_r8_bit_bound: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> bcnt < 7'd96);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [1:0]  bus_raddr,
  output logic [31:0] bus_rdata,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;

  logic        busy;
  logic        tick;
  logic        seq_done;
  logic        start_req;
  logic [3:0]  req_tx;
  logic [2:0]  req_rx;
  logic [31:0] cmd_q;
  logic [31:0] data_q;
  logic [31:0] rx_word;

  spi_cmd_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_raddr (bus_raddr),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .seq_done  (seq_done),
    .rx_word   (rx_word),
    .cmd_q     (cmd_q),
    .data_q    (data_q),
    .start_req (start_req),
    .req_tx    (req_tx),
    .req_rx    (req_rx)
  );

  spi_cmd_clkdiv #(.HALF(HALF)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (busy),
    .tick  (tick)
  );

  spi_cmd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .req_tx    (req_tx),
    .req_rx    (req_rx),
    .cmd_q     (cmd_q),
    .data_q    (data_q),
    .tick      (tick),
    .miso      (spi_miso),
    .cs_n      (spi_cs_n),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .busy      (busy),
    .seq_done  (seq_done),
    .rx_word   (rx_word)
  );

  // R4: chip select is low exactly while the engine reports busy
  a_r4_cs_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n == !busy);

endmodule

// File: tb/spi_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb_top;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [1:0]  bus_raddr = 2'd1;
  logic [31:0] bus_rdata;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [7:0] cap [12];

  always #2 clk = ~clk;

  spi_cmd_engine #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_raddr(bus_raddr), .bus_rdata(bus_rdata), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] resp_byte(input int k);
    return 8'(k * 29 + 90);
  endfunction

  function automatic logic resp_bit(input int n);
    logic [7:0] b;
    b = resp_byte(n / 8);
    return b[7 - (n % 8)];
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
    bus_raddr = a;
    #0.5;
    d = bus_rdata;
    bus_raddr = 2'd1;
    #0.5;
  endtask

  task automatic run_txn(input logic [31:0] cmd, input logic [31:0] data,
                         input int txw, input int rxw, input bit poke);
    int txc, rxc, exp_d, d, rises, falls, last_rise, gapbad, csbad;
    logic prev;
    logic [63:0] stream;
    logic [31:0] rd, exp_data;
    logic [7:0] exp_b;
    txc = (txw > 8) ? 8 : txw;
    rxc = (rxw > 4) ? 4 : rxw;
    exp_d = (txc == 0) ? 0 : (8 * (txc + rxc) + 1) * DIV;
    for (int i = 0; i < 12; i++) cap[i] = 8'h00;
    spi_miso = resp_bit(0);
    bus_write(2'd0, cmd);
    bus_write(2'd2, data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h100 | (rxw << 4) | txw;
    @(negedge clk);
    bus_wr = 1'b0;
    d = 0; rises = 0; falls = 0; last_rise = 0; gapbad = 0; csbad = 0; prev = 1'b0;
    bus_raddr = 2'd1;
    #0.1;
    while (bus_rdata[16] && d < 5000) begin
      d++;
      if (spi_cs_n) csbad++;
      if (spi_sck && !prev) begin
        if (rises > 0 && d - last_rise != DIV) gapbad++;
        last_rise = d;
        if (rises / 8 < 12) cap[rises / 8] = {cap[rises / 8][6:0], spi_mosi};
        rises++;
      end
      if (!spi_sck && prev) begin
        if (d - last_rise != HALF) gapbad++;
        falls++;
      end
      spi_miso = resp_bit(falls);
      prev = spi_sck;
      if (poke && d == 20) begin
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h0000_0111;
      end
      if (poke && d == 21) bus_wr = 1'b0;
      @(negedge clk);
      #0.1;
    end
    check(d == exp_d, "R3 busy length", d, exp_d);
    check(csbad == 0 && spi_cs_n == 1'b1, "R4 chip select window", csbad, 0);
    check(spi_sck == 1'b0, "R4 clock idle after end", spi_sck, 0);
    check(rises == 8 * ((txc == 0) ? 0 : txc + rxc), "R5 rising edge count", rises,
          8 * ((txc == 0) ? 0 : txc + rxc));
    check(gapbad == 0, "R11 clock period", gapbad, 0);
    stream = {data, cmd[15:8], cmd[23:16], cmd[31:24], cmd[7:0]};
    if (txc > 0) begin
      for (int k = 0; k < txc + rxc; k++) begin
        exp_b = (k < txc) ? stream[k*8 +: 8] : 8'h00;
        check(cap[k] == exp_b, (k < txc) ? "R6 transmit byte" : "R6 mosi low in receive", cap[k], exp_b);
      end
    end
    exp_data = data;
    if (txc > 0 && rxc > 0) begin
      exp_data = 32'd0;
      for (int j = 0; j < rxc; j++) exp_data[j*8 +: 8] = resp_byte(txc + j);
    end
    read_reg(2'd2, rd);
    check(rd == exp_data, (rxc > 0 && txc > 0) ? "R7 receive packing" : "R10 R7 data kept", rd, exp_data);
    read_reg(2'd1, rd);
    check(rd == 32'((rxc << 4) | txc), "R8 R9 control readback", rd, 32'((rxc << 4) | txc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && spi_mosi == 1'b0, "R1 pin reset",
          {spi_cs_n, spi_sck, spi_mosi}, 3'b100);
    for (int a = 0; a < 3; a++) begin
      read_reg(2'(a), rd);
      check(rd == 32'd0, "R1 register reset", rd, 0);
    end
    bus_write(2'd0, 32'hDEAD_BE03);
    read_reg(2'd0, rd);
    check(rd == 32'hDEAD_BE03, "R2 command readback", rd, 32'hDEAD_BE03);
    bus_write(2'd2, 32'h0BAD_F00D);
    read_reg(2'd2, rd);
    check(rd == 32'h0BAD_F00D, "R2 data readback", rd, 32'h0BAD_F00D);
    bus_write(2'd1, 32'h0000_0034);
    read_reg(2'd1, rd);
    check(rd == 32'h0000_0034, "R2 control fields without launch", rd, 32'h34);
    check(spi_cs_n == 1'b1, "R2 no launch without bit 8", spi_cs_n, 1);
    for (int t = 0; t <= 10; t++) begin
      for (int r = 0; r <= 5; r++) begin
        int i;
        i = t * 6 + r;
        run_txn(32'h9A3C_5E00 ^ (32'(i) * 32'h0101_0107), 32'h1122_3344 + 32'(i) * 32'h0F0F_1F3D,
                t, r, 1'b0);
      end
    end
    // R9: a launch attempt in the middle of a 4/1 transaction
    run_txn(32'h00AB_CD9F, 32'h5566_7788, 4, 1, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule